// File: doc/BRIEF.md
# Shared Delay-Line Slot Scheduler

This block is the electronic control for a slotted N-input packet switch. Its packets are steered by wavelength and buffered in a bank of K fixed delay lines that every output shares. Each clock cycle is one packet slot. In each slot every input presents a valid flag and the index of the output its packet wants. For every valid packet the scheduler returns four things: a wavelength code equal to the destination, the delay line that packet must take, a one-hot row of gate enables for that line, and either an accept or a drop.

No packet memory is held. Each output instead keeps a single backlog count: the number of slots until that output is next free to send. A packet that gets delay d leaves the bank d slots after it arrived. Handing out consecutive delays keeps each output's departures in first-in first-out order. If an output's backlog would push a packet to delay K or beyond, that packet is dropped.

Top module: `lambda_delay_sched`

## Requirements
- R1: For every valid input, the wavelength code out for that input equals its destination index. An invalid input gives code 0.
- R2: An accepted input has exactly one gate enable set in its row of K, at bit position equal to its delay-line select. Dropped and idle inputs have an all-zero row and a select of 0.
- R3: All results for the packets of a slot appear on the outputs on the clock edge after the inputs were sampled: one cycle of latency.
- R4: A packet for an output with no backlog is given delay 0.
- R5: Packets for the same output in the same slot are served in ascending input index. Each one takes the next delay after the previous one.
- R6: Over several slots, the delay of a packet equals the output's next free departure slot minus the current slot. This gives first-in first-out departures per output.
- R7: The backlog of every output falls by one each slot and never goes below zero. After a gap at least as long as its backlog, an output again hands out delay 0.
- R8: A packet whose required delay is K or more gets the drop flag with accept low. A drop does not add to the output's backlog.
- R9: At most K packets are ever in flight for one output. In a slot where the backlog reaches K, every later packet for that output is dropped.
- R10: Reset clears all backlogs and holds every gate enable, accept, drop, select and code output at 0.
- R11: An input with its valid flag low changes no backlog, whatever destination it shows. It produces neither accept nor drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | N | Packet present on each input this slot |
| inDest | input | N*PW | Destination output index per input, input i at bits [i*PW +: PW] |
| outAccept | output | N | Packet on input i was given a delay line |
| outDrop | output | N | Packet on input i was dropped |
| outWave | output | N*PW | Wavelength code per input, equal to destination |
| outLine | output | N*LW | Delay-line select per input, in slots |
| outGate | output | N*K | Gate-matrix enables, row i at bits [i*K +: K] |

## Verification
The bound checker watches, on every cycle, how the outputs relate to one another. It checks that accept and drop never occur together, that every accepted row has one gate at the selected line and every other row is blank, and that two accepted packets for the same output in one slot are ordered by input index. It also checks one-cycle latency against the sampled inputs, and that the outputs are clear under reset. Whether a delay value is actually right depends on history across slots: backlog decay over idle gaps, drops once an output is full, invalid inputs leaving the backlog alone, and clearing by a mid-run reset. Only the bench's scenarios can show these, by comparing with a next-free-slot model.

// File: rtl/lambda_delay_sched_pkg.sv
package lambda_delay_sched_pkg;
  // widest delay value a strobe can carry; K must not exceed 2**DLY_MAX_W
  localparam int unsigned DLY_MAX_W = 8;

  // per-input strobe handed from the allocator to the datapath
  typedef struct packed {
    logic                 valid;
    logic                 accept;
    logic [DLY_MAX_W-1:0] delay;
  } slotStrb_t;
endpackage

// File: rtl/lambda_delay_sched_ctrl.sv
module lambda_delay_sched_ctrl
  import lambda_delay_sched_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned K  = 8,
  parameter int unsigned PW = 2,
  parameter int unsigned CW = 4
) (
  input  logic [N-1:0]    inValid,
  input  logic [N*PW-1:0] inDest,
  input  logic [N*CW-1:0] effBacklog,
  output slotStrb_t [N-1:0] strb,
  output logic [N*CW-1:0] addCnt
);

  // Delay of input i = backlog of its output + earlier valid inputs
  // for the same output this slot. Once that sum reaches K every later
  // packet for the output is also dropped, so acceptance of earlier
  // inputs need not be known.
  always_comb begin
    int cnt;
    int tot;
    logic [PW-1:0] di;
    logic [PW-1:0] dj;
    for (int i = 0; i < N; i++) begin
      di  = inDest[i*PW +: PW];
      cnt = 0;
      for (int j = 0; j < i; j++) begin
        dj = inDest[j*PW +: PW];
        if (inValid[j] && (dj == di)) cnt = cnt + 1;
      end
      tot = int'(effBacklog[int'(di)*CW +: CW]) + cnt;
      strb[i].valid  = inValid[i];
      strb[i].accept = inValid[i] && (tot < int'(K));
      strb[i].delay  = (inValid[i] && (tot < int'(K))) ? DLY_MAX_W'(tot) : '0;
    end
  end

  // accepted packets per output this slot
  always_comb begin
    int ac;
    for (int o = 0; o < N; o++) begin
      ac = 0;
      for (int i = 0; i < N; i++) begin
        if (strb[i].accept && (int'(inDest[i*PW +: PW]) == o)) ac = ac + 1;
      end
      addCnt[o*CW +: CW] = CW'(ac);
    end
  end

endmodule

// File: rtl/lambda_delay_sched_dp.sv
module lambda_delay_sched_dp
  import lambda_delay_sched_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned K  = 8,
  parameter int unsigned PW = 2,
  parameter int unsigned LW = 3,
  parameter int unsigned CW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N*PW-1:0]   inDest,
  input  slotStrb_t [N-1:0] strb,
  input  logic [N*CW-1:0]   addCnt,
  output logic [N*CW-1:0]   effBacklog,
  output logic [N-1:0]      outAccept,
  output logic [N-1:0]      outDrop,
  output logic [N*PW-1:0]   outWave,
  output logic [N*LW-1:0]   outLine,
  output logic [N*K-1:0]    outGate
);

  // slots until each output is next free, as stored last slot
  logic [CW-1:0] backlog [N];
  logic [N*K-1:0] gateNext;

  // one slot has passed since the value was stored: decay, floor at zero
  always_comb begin
    for (int o = 0; o < N; o++) begin
      effBacklog[o*CW +: CW] = (backlog[o] != '0) ? (backlog[o] - CW'(1)) : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int o = 0; o < N; o++) backlog[o] <= '0;
    end else begin
      for (int o = 0; o < N; o++) begin
        backlog[o] <= effBacklog[o*CW +: CW] + addCnt[o*CW +: CW];
      end
    end
  end

  // gate-matrix row decode per input
  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < K; k++) begin
        gateNext[i*K + k] = strb[i].accept && (int'(strb[i].delay) == k);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAccept <= '0;
      outDrop   <= '0;
      outWave   <= '0;
      outLine   <= '0;
      outGate   <= '0;
    end else begin
      outGate <= gateNext;
      for (int i = 0; i < N; i++) begin
        outAccept[i]          <= strb[i].accept;
        outDrop[i]            <= strb[i].valid && !strb[i].accept;
        outWave[i*PW +: PW]   <= strb[i].valid ? inDest[i*PW +: PW] : '0;
        outLine[i*LW +: LW]   <= strb[i].accept ? strb[i].delay[LW-1:0] : '0;
      end
    end
  end

endmodule

// File: rtl/lambda_delay_sched.sv
module lambda_delay_sched
  import lambda_delay_sched_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned K = 8,
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned LW = $clog2(K),
  localparam int unsigned CW = $clog2(K + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N-1:0]    inValid,
  input  logic [N*PW-1:0] inDest,
  output logic [N-1:0]    outAccept,
  output logic [N-1:0]    outDrop,
  output logic [N*PW-1:0] outWave,
  output logic [N*LW-1:0] outLine,
  output logic [N*K-1:0]  outGate
);

  slotStrb_t [N-1:0] strb;
  logic [N*CW-1:0]   addCnt;
  logic [N*CW-1:0]   effBacklog;

  lambda_delay_sched_ctrl #(.N(N), .K(K), .PW(PW), .CW(CW)) u_ctrl (
    .inValid    (inValid),
    .inDest     (inDest),
    .effBacklog (effBacklog),
    .strb       (strb),
    .addCnt     (addCnt)
  );

  lambda_delay_sched_dp #(.N(N), .K(K), .PW(PW), .LW(LW), .CW(CW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inDest     (inDest),
    .strb       (strb),
    .addCnt     (addCnt),
    .effBacklog (effBacklog),
    .outAccept  (outAccept),
    .outDrop    (outDrop),
    .outWave    (outWave),
    .outLine    (outLine),
    .outGate    (outGate)
  );

endmodule

// File: rtl/lambda_delay_sched_chk.sv
module lambda_delay_sched_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned K  = 8,
  parameter int unsigned PW = 2,
  parameter int unsigned LW = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic [N-1:0]    inValid,
  input logic [N*PW-1:0] inDest,
  input logic [N-1:0]    outAccept,
  input logic [N-1:0]    outDrop,
  input logic [N*PW-1:0] outWave,
  input logic [N*LW-1:0] outLine,
  input logic [N*K-1:0]  outGate
);

  // set once a full slot has run out of reset
  logic armed;
  logic rstSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end
  always_ff @(posedge clk) rstSeen <= !rstN;

  // R10
  always @(negedge clk) begin
    if (rstSeen && !rstN) begin
      reset_clear_chk: assert (outGate == '0 && outAccept == '0 && outDrop == '0
                               && outLine == '0 && outWave == '0);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_in
    // R8
    drop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(outAccept[i] && outDrop[i]));
    // R2
    gate_one_chk: assert property (@(posedge clk) disable iff (!rstN)
      outAccept[i] |-> ($countones(outGate[i*K +: K]) == 1));
    // R2
    gate_line_chk: assert property (@(posedge clk) disable iff (!rstN)
      outAccept[i] |-> outGate[i*K + int'(outLine[i*LW +: LW])]);
    // R2
    gate_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !outAccept[i] |-> (outGate[i*K +: K] == '0));
    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rstN)
      armed |-> ((outAccept[i] || outDrop[i]) == $past(inValid[i])));
    // R1
    wave_chk: assert property (@(posedge clk) disable iff (!rstN)
      (armed && outAccept[i]) |-> (outWave[i*PW +: PW] == $past(inDest[i*PW +: PW])));
    for (genvar j = i + 1; j < N; j++) begin : g_pair
      // R5
      same_slot_order_chk: assert property (@(posedge clk) disable iff (!rstN)
        (outAccept[i] && outAccept[j] && (outWave[i*PW +: PW] == outWave[j*PW +: PW]))
          |-> (outLine[i*LW +: LW] < outLine[j*LW +: LW]));
    end
  end

endmodule

bind lambda_delay_sched lambda_delay_sched_chk #(.N(N), .K(K), .PW(PW), .LW(LW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inDest    (inDest),
  .outAccept (outAccept),
  .outDrop   (outDrop),
  .outWave   (outWave),
  .outLine   (outLine),
  .outGate   (outGate)
);

// File: tb/test_lambda_delay_sched.sv
module test_lambda_delay_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int K  = 8;
  localparam int PW = 2;
  localparam int LW = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N-1:0]    inValid = '0;
  logic [N*PW-1:0] inDest = '0;
  logic [N-1:0]    outAccept;
  logic [N-1:0]    outDrop;
  logic [N*PW-1:0] outWave;
  logic [N*LW-1:0] outLine;
  logic [N*K-1:0]  outGate;

  lambda_delay_sched #(.N(N), .K(K)) i_lambda_delay_sched (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest),
    .outAccept(outAccept), .outDrop(outDrop), .outWave(outWave),
    .outLine(outLine), .outGate(outGate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [N-1:0]    acc;
    logic [N-1:0]    drp;
    logic [N*PW-1:0] wave;
    logic [N*LW-1:0] line;
    logic [N*K-1:0]  gate;
    string           tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  int   nextFree [N];
  int   curSlot = 0;
  string curTag = "R4";
  bit   done = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // model: next free departure slot per output
  task automatic modelReset();
    for (int o = 0; o < N; o++) nextFree[o] = 0;
    curSlot = 0;
  endtask

  task automatic driveSlot(input logic [N-1:0] v, input logic [N*PW-1:0] d);
    exp_t e;
    @(negedge clk);
    inValid = v;
    inDest  = d;
    e.acc = '0; e.drp = '0; e.wave = '0; e.line = '0; e.gate = '0;
    e.tag = curTag;
    for (int i = 0; i < N; i++) begin
      if (v[i]) begin
        int o;
        int dl;
        o = int'(d[i*PW +: PW]);
        e.wave[i*PW +: PW] = d[i*PW +: PW];
        if (nextFree[o] < curSlot) nextFree[o] = curSlot;
        dl = nextFree[o] - curSlot;
        if (dl >= K) begin
          e.drp[i] = 1'b1;
        end else begin
          e.acc[i] = 1'b1;
          e.line[i*LW +: LW] = LW'(dl);
          e.gate[i*K + dl] = 1'b1;
          nextFree[o] = nextFree[o] + 1;
        end
      end
    end
    curSlot++;
    expQ.push_back(e);
  endtask

  function automatic logic [N*PW-1:0] dests(input int d0, input int d1, input int d2, input int d3);
    logic [N*PW-1:0] r;
    r = {PW'(d3), PW'(d2), PW'(d1), PW'(d0)};
    return r;
  endfunction

  // monitor: compare one expected slot per edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        chk({e.tag, "/R6"}, "accept", 64'(outAccept), 64'(e.acc));
        chk({e.tag, "/R8"}, "drop",   64'(outDrop),   64'(e.drp));
        chk({e.tag, "/R1"}, "wave",   64'(outWave),   64'(e.wave));
        chk({e.tag, "/R6"}, "line",   64'(outLine),   64'(e.line));
        chk({e.tag, "/R2"}, "gate",   64'(outGate),   64'(e.gate));
      end
    end
  end

  task automatic checkReset();
    @(posedge clk);
    #1;
    chk("R10", "gate",   64'(outGate),   64'd0);
    chk("R10", "accept", 64'(outAccept), 64'd0);
    chk("R10", "drop",   64'(outDrop),   64'd0);
    chk("R10", "line",   64'(outLine),   64'd0);
  endtask

  task automatic idle(input int n);
    for (int s = 0; s < n; s++) driveSlot('0, '0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    checkReset();                                   // R10
    @(negedge clk);
    rstN = 1'b1;

    // R4: idle output gives delay 0
    curTag = "R4";
    driveSlot(4'b0001, dests(2, 0, 0, 0));
    driveSlot(4'b0000, '0);

    // R5: four same-slot packets for output 1
    curTag = "R5";
    driveSlot(4'b1111, dests(1, 1, 1, 1));
    // R6: next slot, two more for output 1 continue the sequence
    curTag = "R6";
    driveSlot(4'b0101, dests(1, 0, 1, 0));
    driveSlot(4'b1010, dests(0, 1, 0, 3));

    // R9/R8: flood output 0 until it saturates
    curTag = "R9";
    for (int s = 0; s < 4; s++) driveSlot(4'b1111, dests(0, 0, 0, 0));
    curTag = "R8";
    driveSlot(4'b1111, dests(0, 0, 0, 0));

    // R7: decay over an idle gap
    curTag = "R7";
    idle(12);
    driveSlot(4'b1001, dests(0, 0, 0, 1));

    // R11: invalid inputs showing destinations leave backlog alone
    curTag = "R11";
    for (int s = 0; s < 6; s++) driveSlot(4'b0000, dests(3, 3, 3, 3));
    driveSlot(4'b0100, dests(3, 3, 3, 3));

    // R3/R6: mixed traffic
    curTag = "R3";
    for (int s = 0; s < 400; s++) begin
      logic [N-1:0] v;
      logic [N*PW-1:0] d;
      v = N'($urandom);
      d = (N*PW)'($urandom);
      if (s % 50 < 20) d = {PW'(0), d[PW +: PW], PW'(0), d[0 +: PW]};
      driveSlot(v, d);
    end
    idle(2);

    // R10: reset with backlog present, then delay 0 again
    curTag = "R6";
    driveSlot(4'b1111, dests(2, 2, 2, 2));
    driveSlot(4'b1111, dests(2, 2, 2, 2));
    @(negedge clk);
    inValid = '0;
    #1;
    wait (expQ.size() == 0);
    @(negedge clk);
    rstN = 1'b0;
    modelReset();
    checkReset();                                   // R10
    @(negedge clk);
    rstN = 1'b1;
    curTag = "R10";
    driveSlot(4'b0001, dests(2, 0, 0, 0));
    idle(3);
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule